// File: doc/BRIEF.md
# Dual-Divider Edge-Point PWM Generator

This block produces one pulse-width-modulated output from a flat set of configuration inputs. Its timebase comes from two prescalers in series: an exponential stage that divides the clock by a power of two, and a linear stage that divides by one more than its setting. Every prescaler tick moves an 8-bit period counter, and the waveform rises and falls where that counter meets two programmable compare points.

A pin stage then applies inversion, a static level for when the generator is stopped, and an open-drain mode that drives only low. The registered pin value and its active-low output enable are also the status values that software reads back. Compare points and the period go into shadow registers that load at the period boundary. Duty changes are therefore glitch-free unless the immediate-update input is set.

A two-state controller (`ST_OFF`, `ST_RUN`) gates the timebase. The transition `start` (`ST_OFF` to `ST_RUN`) happens on the first edge at which both enables are high. The transition `stop` (`ST_RUN` to `ST_OFF`) happens on the first edge at which either enable is low. The generator counts only while the state is `ST_RUN` and both enables are still high; that condition is called *running* below.

Top module: `pwm_edge_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_o` is 0 and `pwm_oe_n` is 1.
- R2: While running, the prescaler ticks once every 2^`cfg_div_exp` × (`cfg_div_lin`+1) clock cycles. `cfg_div_exp` 0 gives divide-by-1 and 15 gives divide-by-32768; `cfg_div_lin` 0 gives divide-by-1 and 255 gives divide-by-256.
- R3: On each tick the period counter counts 0, 1, … up to the active period value inclusive, then returns to 0. One PWM period is therefore (period+1) ticks.
- R4: Let c be the counter value, r the active rise point and f the active fall point. If r<f, the waveform is high when r ≤ c and either c < f or f = 255. If r>f, it is high when c ≥ r or c < f.
- R5: Rise 0 with fall 255 gives 100% duty. Equal rise and fall points give a waveform that is low for the whole period.
- R6: The block runs only with both `cfg_clk_en` and `cfg_pin_en` high. When it is not running, both prescalers and the counter are held at 0, and the pin value equals `cfg_idle_level`. After a restart, counting begins at count 0.
- R7: While running, `cfg_invert` = 1 gives a pin value that is the inverse of the waveform.
- R8: With `cfg_open_drain` = 1, `pwm_o` is 0 and `pwm_oe_n` equals the pin value (released when high). With `cfg_open_drain` = 0, `pwm_o` equals the pin value and `pwm_oe_n` is 0.
- R9: With `cfg_sync_off` = 0, new period, rise and fall values take effect only at the period wrap, or while the block is not running. With `cfg_sync_off` = 1 they take effect at once.
- R10: `pwm_o` and `pwm_oe_n` are registered. The values after a clock edge reflect the configuration and counter state just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_en | input | 1 | Timebase enable |
| cfg_pin_en | input | 1 | Output generation enable |
| cfg_div_exp | input | 4 | Exponential prescaler setting, divide by 2^n |
| cfg_div_lin | input | 8 | Linear prescaler setting, divide by n+1 |
| cfg_invert | input | 1 | Invert waveform at pin |
| cfg_open_drain | input | 1 | Drive low only, release high |
| cfg_idle_level | input | 1 | Pin value while not running |
| cfg_sync_off | input | 1 | Apply period and compare points immediately |
| cfg_period | input | 8 | Last counter value of a period |
| cfg_rise | input | 8 | Count at which the waveform goes high |
| cfg_fall | input | 8 | Count at which the waveform goes low |
| pwm_o | output | 1 | Registered pin value (also status) |
| pwm_oe_n | output | 1 | Registered active-low output enable (also status) |

## Verification
The delicate coincidence is a configuration change arriving in the same cycle as the period wrap. In that cycle the shadow registers load and the counter returns to 0, so the new compare points must govern count 0. A disable arriving in the wrap cycle is a second case of the same coincidence. Both are provoked by random changes to period, compare points and enables in every few cycles, with small periods and dividers so that wraps are dense. The bench judges each cycle against a cycle model written from R2 to R10. Directed duty counts over whole periods pin the absolute duty values.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
    parameter int PT_W = 8;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_t;

    typedef struct packed {
        logic [PT_W-1:0] period;
        logic [PT_W-1:0] rise;
        logic [PT_W-1:0] fall;
    } edge_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] div_exp,
    input  logic [LIN_W-1:0] div_lin,
    output logic             tick
);
    localparam int EXP_CNT_W = (1 << EXP_W) - 1;

    logic [EXP_CNT_W-1:0] exp_cnt;
    logic [EXP_CNT_W-1:0] exp_mask;
    logic [LIN_W-1:0]     lin_cnt;
    logic                 exp_tick;

    // mask = 2^div_exp - 1, one bit per generated comparator
    for (genvar i = 0; i < EXP_CNT_W; i++) begin : g_mask
        assign exp_mask[i] = (EXP_W'(i) < div_exp);
    end

    assign exp_tick = run && (exp_cnt == exp_mask);
    assign tick     = exp_tick && (lin_cnt == div_lin);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_cnt <= '0;
            lin_cnt <= '0;
        end else if (!run) begin
            exp_cnt <= '0;
            lin_cnt <= '0;
        end else begin
            exp_cnt <= exp_tick ? '0 : exp_cnt + 1'b1;
            if (exp_tick)
                lin_cnt <= (lin_cnt == div_lin) ? '0 : lin_cnt + 1'b1;
        end
    end

    // R2: the linear stage only moves on an exponential-stage tick
    a_r2_lin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !exp_tick) |=> $stable(lin_cnt));

    // R6: a stopped prescaler is cleared
    a_r6_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (exp_cnt == '0 && lin_cnt == '0));
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
    import pwm_edge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            sync_off,
    input  edge_cfg_t       cfg,
    output logic            wave
);
    localparam logic [PT_W-1:0] PT_MAX = '1;

    edge_cfg_t       shadow;
    edge_cfg_t       act;
    logic [PT_W-1:0] cnt_q;
    logic            wrap;

    assign act  = sync_off ? cfg : shadow;
    assign wrap = tick && (cnt_q >= act.period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            shadow <= '0;
        end else begin
            if (!run)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (sync_off || !run || wrap)
                shadow <= cfg;
        end
    end

    always_comb begin
        if (act.rise == act.fall)
            wave = 1'b0;
        else if (act.rise < act.fall)
            wave = (cnt_q >= act.rise) && ((cnt_q < act.fall) || (act.fall == PT_MAX));
        else
            wave = (cnt_q >= act.rise) || (cnt_q < act.fall);
    end

    // R3: a wrap returns the counter to zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt_q == '0));

    // R3: between ticks the counter holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

    // R6: stopping clears the counter
    a_r6_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    // R9: deferred values stay put until the boundary
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_off && !wrap) |=> $stable(shadow));
endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wave,
    input  logic invert,
    input  logic open_drain,
    input  logic idle_level,
    output logic pin_o,
    output logic oe_n_o
);
    logic pin_val;

    assign pin_val = run ? (wave ^ invert) : idle_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_o  <= 1'b0;
            oe_n_o <= 1'b1;
        end else begin
            pin_o  <= open_drain ? 1'b0 : pin_val;
            oe_n_o <= open_drain ? pin_val : 1'b0;
        end
    end

    // R8: open-drain never drives a high value
    a_r8_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        open_drain |=> !pin_o);

    // R8: push-pull keeps the enable asserted
    a_r8_pp_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !open_drain |=> !oe_n_o);

    // R6: idle level shows when stopped in push-pull
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !open_drain) |=> (pin_o == $past(idle_level)));
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_clk_en,
    input  logic             cfg_pin_en,
    input  logic [EXP_W-1:0] cfg_div_exp,
    input  logic [LIN_W-1:0] cfg_div_lin,
    input  logic             cfg_invert,
    input  logic             cfg_open_drain,
    input  logic             cfg_idle_level,
    input  logic             cfg_sync_off,
    input  logic [PT_W-1:0]  cfg_period,
    input  logic [PT_W-1:0]  cfg_rise,
    input  logic [PT_W-1:0]  cfg_fall,
    output logic             pwm_o,
    output logic             pwm_oe_n
);
    run_state_t state, state_nx;
    logic       enable;
    logic       run;
    logic       tick;
    logic       wave;
    edge_cfg_t  cfg;

    assign enable = cfg_clk_en && cfg_pin_en;
    assign cfg    = '{period: cfg_period, rise: cfg_rise, fall: cfg_fall};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        run      = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (enable) state_nx = ST_RUN;
            end
            ST_RUN: begin
                run = enable;
                if (!enable) state_nx = ST_OFF;
            end
        endcase
    end

    pwm_prescaler #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_exp (cfg_div_exp),
        .div_lin (cfg_div_lin),
        .tick    (tick)
    );

    pwm_period_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .sync_off (cfg_sync_off),
        .cfg      (cfg),
        .wave     (wave)
    );

    pwm_pin_stage u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .wave       (wave),
        .invert     (cfg_invert),
        .open_drain (cfg_open_drain),
        .idle_level (cfg_idle_level),
        .pin_o      (pwm_o),
        .oe_n_o     (pwm_oe_n)
    );

    // R6: no tick outside the running condition
    a_r6_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !tick);

    // R6: a disable always leads to the off state
    a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_OFF));
endmodule

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 0, pin_en = 0, inv = 0, od = 0, lvl = 0, soff = 0;
    logic [3:0] dexp = 0;
    logic [7:0] dlin = 0, per = 0, rise = 0, fall = 0;
    logic       pwm_o, pwm_oe_n;

    int checks = 0;
    int failures = 0;
    string tag = "R10";

    // reference state
    int m_st = 0, m_e = 0, m_l = 0, m_c = 0, m_sp = 0, m_sr = 0, m_sf = 0;
    int m_out = 0, m_oen = 1;
    int hi_cnt, oen_cnt;

    always #4 clk = ~clk;

    pwm_edge_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_clk_en(clk_en), .cfg_pin_en(pin_en),
        .cfg_div_exp(dexp), .cfg_div_lin(dlin), .cfg_invert(inv),
        .cfg_open_drain(od), .cfg_idle_level(lvl), .cfg_sync_off(soff),
        .cfg_period(per), .cfg_rise(rise), .cfg_fall(fall),
        .pwm_o(pwm_o), .pwm_oe_n(pwm_oe_n)
    );

    function automatic int wave_f(int c, int r, int f);
        if (r == f) return 0;
        if (r < f) return (c >= r && (c < f || f == 255)) ? 1 : 0;
        return (c >= r || c < f) ? 1 : 0;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // advance the model with the inputs now applied, then compare after the edge
    task automatic step();
        int run, ap, ar, af, mask, et, tk, wr, pv;
        run  = (m_st == 1 && clk_en && pin_en) ? 1 : 0;
        ap   = soff ? int'(per)  : m_sp;
        ar   = soff ? int'(rise) : m_sr;
        af   = soff ? int'(fall) : m_sf;
        mask = (1 << dexp) - 1;
        et   = (run == 1 && m_e == mask) ? 1 : 0;
        tk   = (et == 1 && m_l == int'(dlin)) ? 1 : 0;
        wr   = (tk == 1 && m_c >= ap) ? 1 : 0;
        pv   = run ? (wave_f(m_c, ar, af) ^ int'(inv)) : int'(lvl);
        m_out = od ? 0 : pv;
        m_oen = od ? pv : 0;
        if (soff || !run || wr) begin m_sp = per; m_sr = rise; m_sf = fall; end
        if (!run) begin m_e = 0; m_l = 0; m_c = 0; end
        else begin
            if (tk) m_c = wr ? 0 : m_c + 1;
            if (et) m_l = (m_l == int'(dlin)) ? 0 : m_l + 1;
            m_e = et ? 0 : m_e + 1;
        end
        m_st = (clk_en && pin_en) ? 1 : 0;
        @(posedge clk);
        @(negedge clk);
        check(tag, pwm_o, m_out, "pwm_o");
        check(tag, pwm_oe_n, m_oen, "pwm_oe_n");
        hi_cnt  += pwm_o;
        oen_cnt += pwm_oe_n;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic setup(int h, int l, int p, int r, int f, int iv, int o, int sync_off);
        clk_en = 0; pin_en = 0;
        steps(3);
        dexp = 4'(h); dlin = 8'(l); per = 8'(p); rise = 8'(r); fall = 8'(f);
        inv = 1'(iv); od = 1'(o); soff = 1'(sync_off);
        clk_en = 1; pin_en = 1;
        steps(600);
    endtask

    task automatic measure(int n);
        hi_cnt = 0; oen_cnt = 0;
        steps(n);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", pwm_o, 0, "pwm_o in reset");
        check("R1", pwm_oe_n, 1, "pwm_oe_n in reset");
        rst_n = 1'b1;
        steps(4);

        // R4: 3 high counts out of 10 per period
        tag = "R4";
        setup(0, 0, 9, 2, 5, 0, 0, 0);
        measure(100);
        check("R4", hi_cnt, 30, "duty count r2 f5 p9");
        // R4: wrapped window, rise above fall
        setup(0, 0, 9, 7, 2, 0, 0, 0);
        measure(100);
        check("R4", hi_cnt, 50, "duty count r7 f2 p9");

        // R2/R3: divide by 2*3, period 60 clocks
        tag = "R2";
        setup(1, 2, 9, 2, 5, 0, 0, 0);
        measure(120);
        check("R2", hi_cnt, 36, "duty count with prescale 6");
        tag = "R3";
        setup(2, 0, 4, 0, 2, 0, 0, 0);
        measure(80);
        check("R3", hi_cnt, 32, "duty count period 5 div 4");

        // R5: full duty and equal points
        tag = "R5";
        setup(0, 0, 255, 0, 255, 0, 0, 0);
        measure(256);
        check("R5", hi_cnt, 256, "full duty");
        setup(0, 0, 9, 4, 4, 0, 0, 0);
        measure(100);
        check("R5", hi_cnt, 0, "equal points");

        // R7: inversion
        tag = "R7";
        setup(0, 0, 9, 2, 5, 1, 0, 0);
        measure(100);
        check("R7", hi_cnt, 70, "inverted duty");

        // R8: open drain
        tag = "R8";
        setup(0, 0, 9, 2, 5, 0, 1, 0);
        measure(100);
        check("R8", hi_cnt, 0, "od pwm_o highs");
        check("R8", oen_cnt, 30, "od release count");

        // R6: idle level with either enable low
        tag = "R6";
        setup(0, 0, 9, 2, 5, 0, 0, 0);
        pin_en = 0; lvl = 1;
        steps(2);
        measure(50);
        check("R6", hi_cnt, 50, "idle level 1 pin_en low");
        pin_en = 1; clk_en = 0; lvl = 0;
        steps(2);
        measure(50);
        check("R6", hi_cnt, 0, "idle level 0 clk_en low");
        check("R6", oen_cnt, 0, "push-pull enable while idle");
        clk_en = 1;
        steps(40);

        // R9: deferred and immediate compare updates mid-period
        tag = "R9";
        setup(0, 1, 9, 0, 8, 0, 0, 0);
        steps(7);
        fall = 8'd2;
        steps(60);
        soff = 1; fall = 8'd6;
        steps(7);
        rise = 8'd5; per = 8'd12;
        steps(60);

        // R10: random configurations with dense boundaries
        tag = "R10";
        for (int k = 0; k < 400; k++) begin
            int pick = $urandom % 16;
            if (pick == 0) clk_en = ~clk_en;
            else if (pick == 1) pin_en = ~pin_en;
            else if (pick < 4) begin dexp = 4'($urandom % 3); dlin = 8'($urandom % 3); end
            else if (pick < 6) soff = 1'($urandom % 2);
            else if (pick < 7) begin inv = 1'($urandom % 2); od = 1'($urandom % 2); lvl = 1'($urandom % 2); end
            else begin
                per  = ($urandom % 8 == 0) ? 8'd255 : 8'($urandom % 12);
                rise = 8'($urandom % 14);
                fall = ($urandom % 6 == 0) ? 8'd255 : 8'($urandom % 14);
            end
            steps(1 + $urandom % 12);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule